// File: doc/BRIEF.md
# CCD Frame and Photodiode Transfer Sequencer

This block keeps the vertical rhythm of an interline CCD camera front end. It counts clock cycles into line periods and line periods into frames, gives the horizontal line generator a one-cycle pulse at the start of every line, and exports the current line number. Once per frame, in the first line slot, it schedules the photodiode-to-vertical-register transfer. During that transfer the phase-two vertical clock leaves its normal low level, rests at a mid pedestal, rises to the high level that empties the photodiodes, and returns through a second mid pedestal. The level is handed to an external three-level driver as a 2-bit code.

Each line after the transfer slot is marked as a light-shielded dark row, an active image row or a vertical overclock row. The marking depends only on the line number. Frames either follow each other without a gap (free-running) or start only on a trigger. A trigger also restarts a frame that is under way. With no electronic shutter the exposure equals the frame period, so the free-running frame length sets the integration time.

Top module: `ccdseq_frame_sequencer`

## Requirements
- R1: While reset is held, and afterwards until a frame starts, the block is idle: `line_start`, `frame_start` and all three row flags are 0, `line_idx` is 0 and `v2_code` is 00.
- R2: With `free_run` = 1 an idle block starts a frame on the next clock. Frames follow each other without a gap, so `frame_start` pulses exactly every LINES*LINE_CYC cycles.
- R3: While running, `line_start` pulses for one cycle every LINE_CYC cycles. `line_idx` counts 0,1,...,LINES-1, and `frame_start` pulses only together with the `line_start` of line 0.
- R4: In line 0 the `v2_code` is low for XFER_LEAD cycles, then mid for PED_CYC cycles, high for HIGH_CYC cycles, mid for PED_CYC cycles, and low for the rest of the line. Defaults: 10 us pedestals and a 17 us high pulse at 125 MHz. The high level never appears outside line 0.
- R5: The level code is 00 for low, 01 for mid and 10 for high. The code 11 is never produced.
- R6: Line 0 carries no row flag. `dark_row` is 1 on lines 1..DARK_ROWS. `active_row` is 1 on the next ACTIVE_ROWS lines. `overclock_row` is 1 on every later line of the frame. At most one flag is 1 at a time.
- R7: With `free_run` = 0, after the last cycle of line LINES-1 the block returns to the idle outputs of R1 and stays there until `trigger`.
- R8: A `trigger` in any cycle, in either mode, makes the next cycle the first cycle of line 0, with `frame_start` = 1. This also happens when the trigger lands inside the high pulse, which is then cut short.
- R9: A `trigger` in the last cycle of a frame with `free_run` = 0 starts a new frame on the next cycle instead of going idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| free_run | input | 1 | 1: frames repeat by themselves; 0: a frame starts only on trigger |
| trigger | input | 1 | Restart the frame at line 0 on the next cycle |
| frame_start | output | 1 | One-cycle pulse in the first cycle of line 0 |
| line_start | output | 1 | One-cycle pulse in the first cycle of every line |
| line_idx | output | IDX_W | Current line number within the frame |
| v2_code | output | 2 | Phase-two vertical level code: 00 low, 01 mid, 10 high |
| dark_row | output | 1 | Current line is a light-shielded dark row |
| active_row | output | 1 | Current line is an active image row |
| overclock_row | output | 1 | Current line is a vertical overclock row |

## Verification
Two events can collide: a trigger and the transfer pulse, or a trigger and the frame wrap. The bench provokes the first by raising `trigger` in a cycle where `v2_code` reads high, and the second by counting to the last cycle of a frame in triggered mode and raising `trigger` there. In both cases the next cycle must show line 0, `frame_start` and the start of the line-0 level schedule. A behavioural model with integer counters predicts every output in every cycle and judges both collisions.

// File: rtl/ccdseq_pkg.sv
package ccdseq_pkg;

  typedef enum logic [1:0] {
    V2_LOW  = 2'b00,
    V2_MID  = 2'b01,
    V2_HIGH = 2'b10
  } v2_lvl_e;

  typedef enum logic [1:0] {
    ROW_XFER   = 2'd0,
    ROW_DARK   = 2'd1,
    ROW_ACTIVE = 2'd2,
    ROW_OVER   = 2'd3
  } row_kind_e;

  // Level of the phase-two clock at cycle 'pix' of the transfer line.
  function automatic v2_lvl_e v2_level(input int unsigned pix,
                                       input int unsigned lead,
                                       input int unsigned ped,
                                       input int unsigned high);
    v2_lvl_e lvl;
    if (pix < lead)                        lvl = V2_LOW;
    else if (pix < lead + ped)             lvl = V2_MID;
    else if (pix < lead + ped + high)      lvl = V2_HIGH;
    else if (pix < lead + 2 * ped + high)  lvl = V2_MID;
    else                                   lvl = V2_LOW;
    return lvl;
  endfunction

  // Kind of row carried by line 'line' of the frame.
  function automatic row_kind_e row_kind(input int unsigned line,
                                         input int unsigned dark,
                                         input int unsigned active);
    row_kind_e k;
    if (line == 0)                    k = ROW_XFER;
    else if (line <= dark)            k = ROW_DARK;
    else if (line <= dark + active)   k = ROW_ACTIVE;
    else                              k = ROW_OVER;
    return k;
  endfunction

endpackage

// File: rtl/ccdseq_timebase.sv
module ccdseq_timebase #(
  parameter int LINE_CYC = 7937,
  parameter int LINES    = 525,
  parameter int PIX_W    = 13,
  parameter int LINE_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              free_run,
  input  logic              trigger,
  output logic              run,
  output logic [PIX_W-1:0]  pix,
  output logic [LINE_W-1:0] line,
  output logic              line_end,
  output logic              frame_end
);
  localparam logic [PIX_W-1:0]  PIX_LAST  = PIX_W'(LINE_CYC - 1);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES - 1);

  logic              run_q;
  logic [PIX_W-1:0]  pix_q;
  logic [LINE_W-1:0] line_q;

  assign line_end  = run_q && (pix_q == PIX_LAST);
  assign frame_end = line_end && (line_q == LINE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pix_q  <= '0;
      line_q <= '0;
    end else if (trigger) begin
      run_q  <= 1'b1;
      pix_q  <= '0;
      line_q <= '0;
    end else if (!run_q) begin
      run_q  <= free_run;
      pix_q  <= '0;
      line_q <= '0;
    end else if (line_end) begin
      pix_q <= '0;
      if (frame_end) begin
        line_q <= '0;
        run_q  <= free_run;
      end else begin
        line_q <= line_q + 1'b1;
      end
    end else begin
      pix_q <= pix_q + 1'b1;
    end
  end

  assign run  = run_q;
  assign pix  = pix_q;
  assign line = line_q;
endmodule

// File: rtl/ccdseq_xfer_shaper.sv
module ccdseq_xfer_shaper
  import ccdseq_pkg::*;
#(
  parameter int PIX_W     = 13,
  parameter int XFER_LEAD = 125,
  parameter int PED_CYC   = 1250,
  parameter int HIGH_CYC  = 2125
) (
  input  logic             run,
  input  logic             in_xfer_line,
  input  logic [PIX_W-1:0] pix,
  output logic [1:0]       v2_code,
  output logic             v2_is_high
);
  v2_lvl_e lvl;

  always_comb begin
    if (run && in_xfer_line)
      lvl = v2_level(32'(pix), XFER_LEAD, PED_CYC, HIGH_CYC);
    else
      lvl = V2_LOW;
  end

  assign v2_code    = lvl;
  assign v2_is_high = (lvl == V2_HIGH);
endmodule

// File: rtl/ccdseq_row_classifier.sv
module ccdseq_row_classifier
  import ccdseq_pkg::*;
#(
  parameter int LINE_W      = 10,
  parameter int DARK_ROWS   = 5,
  parameter int ACTIVE_ROWS = 484
) (
  input  logic              run,
  input  logic [LINE_W-1:0] line,
  output logic              dark_row,
  output logic              active_row,
  output logic              overclock_row
);
  row_kind_e kind;

  assign kind          = row_kind(32'(line), DARK_ROWS, ACTIVE_ROWS);
  assign dark_row      = run && (kind == ROW_DARK);
  assign active_row    = run && (kind == ROW_ACTIVE);
  assign overclock_row = run && (kind == ROW_OVER);
endmodule

// File: rtl/ccdseq_frame_sequencer.sv
module ccdseq_frame_sequencer #(
  parameter int LINE_CYC    = 7937,
  parameter int LINES       = 525,
  parameter int DARK_ROWS   = 5,
  parameter int ACTIVE_ROWS = 484,
  parameter int XFER_LEAD   = 125,
  parameter int PED_CYC     = 1250,
  parameter int HIGH_CYC    = 2125,
  parameter int IDX_W       = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             free_run,
  input  logic             trigger,
  output logic             frame_start,
  output logic             line_start,
  output logic [IDX_W-1:0] line_idx,
  output logic [1:0]       v2_code,
  output logic             dark_row,
  output logic             active_row,
  output logic             overclock_row
);
  localparam int PIX_W = (LINE_CYC > 1) ? $clog2(LINE_CYC) : 1;

  logic             run_w;
  logic [PIX_W-1:0] pix_w;
  logic [IDX_W-1:0] line_w;
  logic             line_end_w;
  logic             frame_end_w;
  logic             xfer_line_w;
  logic             v2_high_w;

  ccdseq_timebase #(
    .LINE_CYC (LINE_CYC),
    .LINES    (LINES),
    .PIX_W    (PIX_W),
    .LINE_W   (IDX_W)
  ) u_timebase (
    .clk       (clk),
    .rst_n     (rst_n),
    .free_run  (free_run),
    .trigger   (trigger),
    .run       (run_w),
    .pix       (pix_w),
    .line      (line_w),
    .line_end  (line_end_w),
    .frame_end (frame_end_w)
  );

  assign xfer_line_w = (line_w == '0);

  ccdseq_xfer_shaper #(
    .PIX_W     (PIX_W),
    .XFER_LEAD (XFER_LEAD),
    .PED_CYC   (PED_CYC),
    .HIGH_CYC  (HIGH_CYC)
  ) u_shaper (
    .run          (run_w),
    .in_xfer_line (xfer_line_w),
    .pix          (pix_w),
    .v2_code      (v2_code),
    .v2_is_high   (v2_high_w)
  );

  ccdseq_row_classifier #(
    .LINE_W      (IDX_W),
    .DARK_ROWS   (DARK_ROWS),
    .ACTIVE_ROWS (ACTIVE_ROWS)
  ) u_rows (
    .run           (run_w),
    .line          (line_w),
    .dark_row      (dark_row),
    .active_row    (active_row),
    .overclock_row (overclock_row)
  );

  assign line_start  = run_w && (pix_w == '0);
  assign frame_start = line_start && xfer_line_w;
  assign line_idx    = line_w;
endmodule

// File: rtl/ccdseq_checker.sv
module ccdseq_checker #(
  parameter int IDX_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trigger,
  input logic             frame_start,
  input logic             line_start,
  input logic [IDX_W-1:0] line_idx,
  input logic [1:0]       v2_code,
  input logic             dark_row,
  input logic             active_row,
  input logic             overclock_row,
  input logic             v2_high_w,
  input logic             frame_end_w
);
  a_r5_no_code11: assert property (@(posedge clk) disable iff (!rst_n)
    v2_code != 2'b11);

  a_r4_high_only_line0: assert property (@(posedge clk) disable iff (!rst_n)
    (v2_code == 2'b10) |-> (line_idx == '0));

  a_r4_high_from_mid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(v2_high_w) |-> ($past(v2_code) == 2'b01));

  a_r6_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dark_row, active_row, overclock_row}));

  a_r3_frame_start_line0: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (line_start && line_idx == '0));

  a_r8_trigger_restart: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> (frame_start && line_idx == '0));

  a_r3_line_step: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && line_idx != '0) |-> (line_idx == $past(line_idx) + 1'b1));

  a_r9_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end_w && !trigger) |=> (line_idx == '0));
endmodule

bind ccdseq_frame_sequencer ccdseq_checker #(.IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .trigger       (trigger),
  .frame_start   (frame_start),
  .line_start    (line_start),
  .line_idx      (line_idx),
  .v2_code       (v2_code),
  .dark_row      (dark_row),
  .active_row    (active_row),
  .overclock_row (overclock_row),
  .v2_high_w     (v2_high_w),
  .frame_end_w   (frame_end_w)
);

// File: tb/ccdseq_frame_sequencer_bench.sv
`timescale 1ns/1ps
module ccdseq_frame_sequencer_bench;
  localparam int LC   = 20;
  localparam int NL   = 12;
  localparam int DK   = 2;
  localparam int AC   = 6;
  localparam int LEAD = 2;
  localparam int PED  = 3;
  localparam int HI   = 4;
  localparam int FRAME = NL * LC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic free_run = 1'b0;
  logic trigger = 1'b0;
  logic frame_start, line_start, dark_row, active_row, overclock_row;
  logic [9:0] line_idx;
  logic [1:0] v2_code;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;

  // reference model state
  int m_run = 0, m_line = 0, m_pix = 0;

  always #4 clk = ~clk;

  ccdseq_frame_sequencer #(
    .LINE_CYC(LC), .LINES(NL), .DARK_ROWS(DK), .ACTIVE_ROWS(AC),
    .XFER_LEAD(LEAD), .PED_CYC(PED), .HIGH_CYC(HI), .IDX_W(10)
  ) u_ccdseq_frame_sequencer (
    .clk(clk), .rst_n(rst_n), .free_run(free_run), .trigger(trigger),
    .frame_start(frame_start), .line_start(line_start), .line_idx(line_idx),
    .v2_code(v2_code), .dark_row(dark_row), .active_row(active_row),
    .overclock_row(overclock_row)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_line = 0; m_pix = 0;
    end else if (trigger) begin
      m_run = 1; m_line = 0; m_pix = 0;
    end else if (m_run == 0) begin
      m_run = free_run ? 1 : 0;
    end else if (m_pix == LC - 1) begin
      m_pix = 0;
      if (m_line == NL - 1) begin
        m_line = 0;
        m_run = free_run ? 1 : 0;
      end else m_line++;
    end else m_pix++;
  end

  function automatic int exp_code();
    int p = m_pix;
    if (m_run == 0 || m_line != 0) return 0;
    if (p < LEAD) return 0;
    if (p < LEAD + PED) return 1;
    if (p < LEAD + PED + HI) return 2;
    if (p < LEAD + PED + HI + PED) return 1;
    return 0;
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (!done) begin
      int e_ls, e_fs, e_dk, e_ac, e_oc;
      e_ls = (m_run != 0 && m_pix == 0) ? 1 : 0;
      e_fs = (e_ls == 1 && m_line == 0) ? 1 : 0;
      e_dk = (m_run != 0 && m_line >= 1 && m_line <= DK) ? 1 : 0;
      e_ac = (m_run != 0 && m_line > DK && m_line <= DK + AC) ? 1 : 0;
      e_oc = (m_run != 0 && m_line > DK + AC) ? 1 : 0;
      chk(int'(line_start) == e_ls, "R3 line_start", int'(line_start), e_ls);
      chk(int'(frame_start) == e_fs, "R3 frame_start", int'(frame_start), e_fs);
      chk(int'(line_idx) == (m_run != 0 ? m_line : 0), "R3 line_idx", int'(line_idx), m_line);
      chk(int'(v2_code) == exp_code(), "R4 v2_code", int'(v2_code), exp_code());
      chk(v2_code != 2'b11, "R5 code 11", int'(v2_code), 0);
      chk(int'(dark_row) == e_dk, "R6 dark_row", int'(dark_row), e_dk);
      chk(int'(active_row) == e_ac, "R6 active_row", int'(active_row), e_ac);
      chk(int'(overclock_row) == e_oc, "R6 overclock_row", int'(overclock_row), e_oc);
    end
  end

  // high pulse length and frame spacing monitors
  int hi_len = 0;
  bit hi_cut = 1'b0;
  int last_fs = -1;
  bit spacing_on = 1'b0;
  always @(negedge clk) begin
    if (!done && rst_n) begin
      if (v2_code == 2'b10) hi_len++;
      else begin
        if (hi_len != 0 && !hi_cut) chk(hi_len == HI, "R4 high length", hi_len, HI);
        hi_len = 0;
        hi_cut = 1'b0;
      end
      if (frame_start) begin
        if (spacing_on && last_fs >= 0) chk(cyc - last_fs == FRAME, "R2 frame spacing", cyc - last_fs, FRAME);
        last_fs = cyc;
      end
    end
  end

  task automatic idle_check(input string req);
    chk(!line_start && !frame_start && !dark_row && !active_row && !overclock_row
        && line_idx == 0 && v2_code == 2'b00, req,
        int'({line_start, frame_start, dark_row, active_row, overclock_row}) + int'(line_idx) + int'(v2_code), 0);
  endtask

  initial begin
    // R1: reset and idle
    repeat (4) @(negedge clk);
    idle_check("R1 in reset");
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    idle_check("R1 idle after reset");

    // R2: free-running start and back-to-back frames
    free_run = 1'b1;
    @(negedge clk);
    chk(frame_start == 1'b1, "R2 start next cycle", int'(frame_start), 1);
    spacing_on = 1'b1;
    repeat (3 * FRAME) @(negedge clk);
    spacing_on = 1'b0;

    // R8: trigger inside the high pulse
    while (v2_code != 2'b10) @(negedge clk);
    @(negedge clk);
    hi_cut = 1'b1;
    trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    chk(frame_start == 1'b1 && line_idx == 0, "R8 restart from high", int'(frame_start), 1);
    chk(v2_code == 2'b00, "R8 high cut short", int'(v2_code), 0);

    // R8: trigger mid-frame in a later line
    repeat (5 * LC + 7) @(negedge clk);
    trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    chk(frame_start == 1'b1, "R8 mid-frame restart", int'(frame_start), 1);

    // R7: triggered mode goes idle at frame end
    free_run = 1'b0;
    repeat (FRAME - 1) @(negedge clk);
    chk(line_idx == NL - 1, "R7 last line", int'(line_idx), NL - 1);
    @(negedge clk);
    idle_check("R7 idle after frame");
    repeat (30) @(negedge clk);
    idle_check("R7 stays idle");
    trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    chk(frame_start == 1'b1, "R7 start on trigger", int'(frame_start), 1);

    // R9: trigger on the last cycle of the frame, triggered mode
    repeat (FRAME - 1) @(negedge clk);
    chk(line_idx == NL - 1, "R9 at last line", int'(line_idx), NL - 1);
    trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    chk(frame_start == 1'b1 && line_idx == 0, "R9 wrap restart", int'(frame_start), 1);
    repeat (FRAME + 5) @(negedge clk);
    idle_check("R9 idle after restarted frame");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule